// File: doc/BRIEF.md
# Ethernet Receive Frame Filter

This block watches a byte-wide stream of incoming Ethernet frames and decides, frame by frame, whether each one should be kept. Each byte arrives with a valid strobe. Start-of-frame and end-of-frame markers accompany the stream, and a CRC-failure flag comes with the final byte. The CRC itself is computed upstream.

The block captures the destination address from the first six bytes and sorts the frame into unicast, multicast or broadcast. It compares a unicast destination with the station address, counts the frame length and applies a set of acceptance controls. The controls cover enable, unicast promiscuity, multicast promiscuity, broadcast acceptance, long frames and keeping errored frames.

Bytes leave through a short delay line. The line is just deep enough to hold the whole destination address, so a frame rejected on its address never appears on the output. Frames whose fate depends on their length or CRC are streamed in full. A verdict record, issued one cycle after the last input byte, tells the consumer whether to commit or discard what it received. The delay line also lets the block optionally drop the trailing four check bytes.

Top module: `eth_rx_filter`

## Requirements
- R1: While reset is applied, and after it is released, `out_valid` and `vd_valid` are 0 until frame bytes arrive.
- R2: A unicast frame whose destination equals `station_addr` is accepted when reception is enabled. `station_addr[47:40]` is compared with the first byte on the wire. The delivered bytes equal the input bytes in order, with `out_sof` on the first and `out_eof` on the last.
- R3: A unicast destination is one whose first byte has bit 0 clear. A unicast frame to any other address delivers no bytes and is rejected, unless `cfg_uc_all` is 1, in which case it is treated like an own-address frame.
- R4: A multicast destination has bit 0 of its first byte set, and its 48 bits are not all 1. Such a frame is accepted only when `cfg_mc_all` is 1. Exactly one of `vd_ucast`, `vd_mcast` and `vd_bcast` is set in each verdict.
- R5: A broadcast destination is all 48 bits set to 1. Such a frame is accepted only when `cfg_bc_ok` is 1. With the default `BC_VIA_MC`=0, `cfg_mc_all` does not admit it.
- R6: When `cfg_rx_en` is 0, every frame is rejected and no byte of it is delivered, whatever the other controls are.
- R7: A frame of fewer than `MIN_LEN` bytes, check bytes included, is rejected with `vd_short`=1. A frame of exactly `MIN_LEN` bytes is not short.
- R8: A frame of more than `MAX_LEN` bytes sets `vd_long`. It is rejected unless `cfg_long_ok` is 1. A frame of exactly `MAX_LEN` bytes is not long.
- R9: `vd_bad` reports `in_fcs_bad` sampled with the last byte. A bad frame is rejected unless `cfg_keep_bad` is 1, in which case it may be accepted with `vd_bad`=1.
- R10: With `cfg_strip_fcs`=1, the final `FCS_BYTES` bytes are not delivered, `out_eof` marks the last byte before them, and `vd_len` is the frame length minus `FCS_BYTES`. Otherwise `vd_len` is the full length.
- R11: `vd_valid` is high for exactly one cycle per frame, in the cycle after the clock edge that takes the last input byte.
- R12: A delivered byte appears on the output `DEPTH` clock edges after the edge that takes it (`DEPTH`=6 by default). Frames must be separated by at least `DEPTH` idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte strobe |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Input byte |
| in_fcs_bad | input | 1 | CRC failure, valid with in_eof |
| cfg_rx_en | input | 1 | Reception enable |
| cfg_uc_all | input | 1 | Accept every unicast destination |
| cfg_mc_all | input | 1 | Accept every multicast destination |
| cfg_bc_ok | input | 1 | Accept broadcast |
| cfg_long_ok | input | 1 | Allow frames above MAX_LEN |
| cfg_keep_bad | input | 1 | Keep frames with CRC failure |
| cfg_strip_fcs | input | 1 | Remove trailing check bytes |
| station_addr | input | 48 | Own address, [47:40] first on wire |
| out_valid | output | 1 | Output byte strobe |
| out_sof | output | 1 | First delivered byte |
| out_eof | output | 1 | Last delivered byte |
| out_data | output | 8 | Output byte |
| vd_valid | output | 1 | Verdict strobe |
| vd_accept | output | 1 | Frame accepted |
| vd_ucast | output | 1 | Unicast destination |
| vd_mcast | output | 1 | Multicast destination |
| vd_bcast | output | 1 | Broadcast destination |
| vd_short | output | 1 | Below MIN_LEN |
| vd_long | output | 1 | Above MAX_LEN |
| vd_bad | output | 1 | CRC failure seen |
| vd_len | output | LEN_W | Delivered length in bytes |

## Verification
The bench builds the filter with `MIN_LEN`=16, `MAX_LEN`=40 and `LEN_W`=8, leaving `FCS_BYTES` and `BC_VIA_MC` at their defaults. The small length window puts both length boundaries within frames of a few dozen bytes: just under and at the minimum, and at and just above the maximum. That leaves room to sweep every address class against every control combination. It also lets check-byte stripping be tested on a minimum-size frame, where the strip marks reach back into the header bytes.

// File: rtl/eth_rxf_pkg.sv
package eth_rxf_pkg;

   localparam int ADDR_BYTES = 6;
   localparam int ADDR_W     = 8 * ADDR_BYTES;

   // one position of the delay line
   typedef struct packed {
      logic       vld;
      logic       first;
      logic       last;
      logic       kill;
      logic [7:0] data;
   } slot_t;

   // destination classification
   typedef struct packed {
      logic ucast;
      logic mcast;
      logic bcast;
      logic own;
   } dcls_t;

   function automatic dcls_t dest_classify(input logic [ADDR_W-1:0] d,
                                           input logic [ADDR_W-1:0] me);
      dcls_t c;
      c.bcast = &d;
      c.ucast = ~d[ADDR_W-8];
      c.mcast = d[ADDR_W-8] & ~c.bcast;
      c.own   = (d == me);
      return c;
   endfunction

endpackage

// File: rtl/eth_rxf_addr.sv
module eth_rxf_addr
   import eth_rxf_pkg::*;
#(
   parameter int LEN_W     = 12,
   parameter bit BC_VIA_MC = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_we,
   input  logic [LEN_W-1:0]  byte_pos,
   input  logic [7:0]        byte_in,
   input  logic [ADDR_W-1:0] station,
   input  logic              rx_en,
   input  logic              uc_all,
   input  logic              mc_all,
   input  logic              bc_ok,
   output dcls_t             cls_now,
   output logic              pass_now,
   output logic              pass_held
);

   logic [ADDR_W-1:0] dest_q;
   logic [ADDR_W-1:0] dest_n;
   logic              bc_allow;
   dcls_t             cls_held;

   // byte b of the frame lands in the b-th most significant octet
   for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_octet
      assign dest_n[ADDR_W-1-8*b -: 8] =
         (byte_we && byte_pos == LEN_W'(b)) ? byte_in : dest_q[ADDR_W-1-8*b -: 8];
   end

   if (BC_VIA_MC) begin : g_bc_wide
      assign bc_allow = bc_ok | mc_all;
   end else begin : g_bc_strict
      assign bc_allow = bc_ok;
   end

   function automatic logic admit(input dcls_t c, input logic en, input logic u,
                                  input logic m, input logic b);
      logic ok;
      if (c.ucast)      ok = c.own | u;
      else if (c.bcast) ok = b;
      else              ok = m;
      return en & ok;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n)       dest_q <= '0;
      else if (byte_we) dest_q <= dest_n;
   end

   always_comb begin
      cls_now   = dest_classify(dest_n, station);
      cls_held  = dest_classify(dest_q, station);
      pass_now  = admit(cls_now, rx_en, uc_all, mc_all, bc_allow);
      pass_held = admit(cls_held, rx_en, uc_all, mc_all, bc_allow);
   end

endmodule

// File: rtl/eth_rxf_verdict.sv
module eth_rxf_verdict
   import eth_rxf_pkg::*;
#(
   parameter int MIN_LEN   = 64,
   parameter int MAX_LEN   = 1536,
   parameter int LEN_W     = 12,
   parameter int FCS_BYTES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic             in_eof,
   input  logic             fcs_bad,
   input  logic             long_ok,
   input  logic             keep_bad,
   input  logic             strip,
   input  dcls_t            cls_now,
   input  logic             pass_now,
   output logic [LEN_W-1:0] byte_pos,
   output logic             vd_valid,
   output logic             vd_accept,
   output logic             vd_ucast,
   output logic             vd_mcast,
   output logic             vd_bcast,
   output logic             vd_short,
   output logic             vd_long,
   output logic             vd_bad,
   output logic [LEN_W-1:0] vd_len
);

   localparam logic [LEN_W-1:0] CNT_TOP = '1;
   localparam logic [LEN_W-1:0] MIN_L   = LEN_W'(MIN_LEN);
   localparam logic [LEN_W-1:0] MAX_L   = LEN_W'(MAX_LEN);
   localparam logic [LEN_W-1:0] FCS_L   = LEN_W'(FCS_BYTES);

   logic [LEN_W-1:0] cnt_q, cnt_n, dlv_len;
   logic             fin, is_short, is_long, take;

   always_comb begin
      if (in_sof)               cnt_n = LEN_W'(1);
      else if (cnt_q == CNT_TOP) cnt_n = CNT_TOP;
      else                      cnt_n = cnt_q + 1'b1;
      byte_pos = cnt_n - 1'b1;
      fin      = in_valid & in_eof;
      is_short = cnt_n < MIN_L;
      is_long  = cnt_n > MAX_L;
      take     = pass_now & ~is_short & ~(is_long & ~long_ok) & ~(fcs_bad & ~keep_bad);
      if (!strip)            dlv_len = cnt_n;
      else if (cnt_n > FCS_L) dlv_len = cnt_n - FCS_L;
      else                   dlv_len = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         vd_valid  <= 1'b0;
         vd_accept <= 1'b0;
         vd_ucast  <= 1'b0;
         vd_mcast  <= 1'b0;
         vd_bcast  <= 1'b0;
         vd_short  <= 1'b0;
         vd_long   <= 1'b0;
         vd_bad    <= 1'b0;
         vd_len    <= '0;
      end else begin
         if (in_valid) cnt_q <= cnt_n;
         vd_valid <= fin;
         if (fin) begin
            vd_accept <= take;
            vd_ucast  <= cls_now.ucast;
            vd_mcast  <= cls_now.mcast;
            vd_bcast  <= cls_now.bcast;
            vd_short  <= is_short;
            vd_long   <= is_long;
            vd_bad    <= fcs_bad;
            vd_len    <= dlv_len;
         end
      end
   end

   a_r11_verdict_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_eof) |=> vd_valid);
   a_r11_no_stray_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_eof) |=> !vd_valid);
   a_r4_one_class: assert property (@(posedge clk) disable iff (!rst_n)
      vd_valid |-> $countones({vd_ucast, vd_mcast, vd_bcast}) == 1);
   a_r7_short_rejected: assert property (@(posedge clk) disable iff (!rst_n)
      (vd_valid && vd_short) |-> !vd_accept);
   a_r8_long_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_eof && !long_ok) |=> !(vd_long && vd_accept));
   a_r9_bad_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_eof && !keep_bad) |=> !(vd_bad && vd_accept));

endmodule

// File: rtl/eth_rxf_line.sv
module eth_rxf_line
   import eth_rxf_pkg::*;
#(
   parameter int DEPTH     = 6,
   parameter int FCS_BYTES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic       in_sof,
   input  logic       in_eof,
   input  logic [7:0] in_data,
   input  logic       strip,
   input  logic       pass_held,
   output logic       out_valid,
   output logic       out_sof,
   output logic       out_eof,
   output logic [7:0] out_data
);

   slot_t line_q [DEPTH];
   slot_t line_n [DEPTH];
   logic  drain_q, advance, fcs_end, any_left;

   assign advance = in_valid | drain_q;
   assign fcs_end = in_valid & in_eof & strip;

   always_comb begin
      line_n[0].vld   = in_valid;
      line_n[0].first = in_sof;
      line_n[0].last  = in_eof & ~strip;
      line_n[0].kill  = fcs_end;
      line_n[0].data  = in_data;
      for (int k = 1; k < DEPTH; k++) begin
         line_n[k] = line_q[k-1];
         if (fcs_end && k < FCS_BYTES)  line_n[k].kill = 1'b1;
         if (fcs_end && k == FCS_BYTES) line_n[k].last = 1'b1;
      end
      any_left = 1'b0;
      for (int k = 0; k < DEPTH; k++) any_left |= line_n[k].vld;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) line_q[k] <= '0;
         drain_q   <= 1'b0;
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
         out_eof   <= 1'b0;
         out_data  <= '0;
      end else begin
         if (advance) line_q <= line_n;
         if (in_valid && in_eof) drain_q <= 1'b1;
         else                    drain_q <= drain_q & any_left;
         out_valid <= advance & line_q[DEPTH-1].vld & ~line_q[DEPTH-1].kill & pass_held;
         out_sof   <= advance & line_q[DEPTH-1].first;
         out_eof   <= advance & line_q[DEPTH-1].last;
         if (advance) out_data <= line_q[DEPTH-1].data;
      end
   end

   // R12: the line must be empty before the next frame begins
   a_r12_gap_kept: assert property (@(posedge clk) disable iff (!rst_n)
      drain_q |-> !in_valid);
   a_r10_eof_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (out_eof || out_sof) |-> out_valid || !pass_held || $past(strip));

endmodule

// File: rtl/eth_rx_filter.sv
module eth_rx_filter
   import eth_rxf_pkg::*;
#(
   parameter int MIN_LEN   = 64,
   parameter int MAX_LEN   = 1536,
   parameter int LEN_W     = 12,
   parameter int FCS_BYTES = 4,
   parameter bit BC_VIA_MC = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic             in_eof,
   input  logic [7:0]       in_data,
   input  logic             in_fcs_bad,
   input  logic             cfg_rx_en,
   input  logic             cfg_uc_all,
   input  logic             cfg_mc_all,
   input  logic             cfg_bc_ok,
   input  logic             cfg_long_ok,
   input  logic             cfg_keep_bad,
   input  logic             cfg_strip_fcs,
   input  logic [47:0]      station_addr,
   output logic             out_valid,
   output logic             out_sof,
   output logic             out_eof,
   output logic [7:0]       out_data,
   output logic             vd_valid,
   output logic             vd_accept,
   output logic             vd_ucast,
   output logic             vd_mcast,
   output logic             vd_bcast,
   output logic             vd_short,
   output logic             vd_long,
   output logic             vd_bad,
   output logic [LEN_W-1:0] vd_len
);

   localparam int DEPTH = (ADDR_BYTES > FCS_BYTES) ? ADDR_BYTES : FCS_BYTES + 1;

   if (FCS_BYTES < 1) begin : g_chk_fcs
      $error("FCS_BYTES must be at least 1");
   end
   if (MIN_LEN <= FCS_BYTES || MIN_LEN > MAX_LEN) begin : g_chk_bounds
      $error("length bounds out of order");
   end
   if (MAX_LEN >= (1 << LEN_W) - 1) begin : g_chk_width
      $error("LEN_W too narrow for MAX_LEN");
   end

   logic [LEN_W-1:0] byte_pos;
   dcls_t            cls_now;
   logic             pass_now, pass_held;

   eth_rxf_addr #(.LEN_W(LEN_W), .BC_VIA_MC(BC_VIA_MC)) u_addr (
      .clk(clk), .rst_n(rst_n),
      .byte_we(in_valid), .byte_pos(byte_pos), .byte_in(in_data),
      .station(station_addr), .rx_en(cfg_rx_en), .uc_all(cfg_uc_all),
      .mc_all(cfg_mc_all), .bc_ok(cfg_bc_ok),
      .cls_now(cls_now), .pass_now(pass_now), .pass_held(pass_held)
   );

   eth_rxf_verdict #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W),
                     .FCS_BYTES(FCS_BYTES)) u_verdict (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .fcs_bad(in_fcs_bad),
      .long_ok(cfg_long_ok), .keep_bad(cfg_keep_bad), .strip(cfg_strip_fcs),
      .cls_now(cls_now), .pass_now(pass_now), .byte_pos(byte_pos),
      .vd_valid(vd_valid), .vd_accept(vd_accept), .vd_ucast(vd_ucast),
      .vd_mcast(vd_mcast), .vd_bcast(vd_bcast), .vd_short(vd_short),
      .vd_long(vd_long), .vd_bad(vd_bad), .vd_len(vd_len)
   );

   eth_rxf_line #(.DEPTH(DEPTH), .FCS_BYTES(FCS_BYTES)) u_line (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
      .strip(cfg_strip_fcs), .pass_held(pass_held),
      .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof), .out_data(out_data)
   );

   a_r6_disabled_rejects: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_eof && !cfg_rx_en) |=> !vd_accept);

endmodule

// File: tb/test_eth_rx_filter.sv
module test_eth_rx_filter;

   localparam int CLK_PERIOD = 10;
   localparam int MINL = 16;
   localparam int MAXL = 40;
   localparam int LW   = 8;
   localparam int FCS  = 4;
   localparam int LAT  = 6;
   localparam logic [47:0] OWN   = 48'h02_11_22_33_44_55;
   localparam logic [47:0] OTHER = 48'h02_11_22_33_44_56;
   localparam logic [47:0] MCAST = 48'h01_00_5E_00_00_01;

   // {dest code, length, bad, en, uc, mc, bc, long, keep, strip, expected accept}
   // dest code: 0 own, 1 other unicast, 2 multicast, 3 broadcast
   localparam int NV = 18;
   localparam logic [18:0] VEC [NV] = '{
      {2'd0, 8'd20, 9'b0_1_000_0_0_0_1},
      {2'd0, 8'd40, 9'b0_1_000_0_0_1_1},
      {2'd1, 8'd20, 9'b0_1_000_0_0_0_0},
      {2'd1, 8'd20, 9'b0_1_100_0_0_0_1},
      {2'd2, 8'd20, 9'b0_1_000_0_0_0_0},
      {2'd2, 8'd20, 9'b0_1_010_0_0_0_1},
      {2'd3, 8'd20, 9'b0_1_000_0_0_0_0},
      {2'd3, 8'd20, 9'b0_1_010_0_0_0_0},
      {2'd3, 8'd20, 9'b0_1_001_0_0_0_1},
      {2'd0, 8'd20, 9'b0_0_111_0_0_0_0},
      {2'd0, 8'd15, 9'b0_1_000_0_0_0_0},
      {2'd0, 8'd16, 9'b0_1_000_0_0_0_1},
      {2'd0, 8'd41, 9'b0_1_000_0_0_0_0},
      {2'd0, 8'd41, 9'b0_1_000_1_0_0_1},
      {2'd0, 8'd20, 9'b1_1_000_0_0_0_0},
      {2'd0, 8'd20, 9'b1_1_000_0_1_0_1},
      {2'd0, 8'd16, 9'b0_1_000_0_0_1_1},
      {2'd1, 8'd20, 9'b1_1_100_0_0_1_0}
   };

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic rst_n, in_valid, in_sof, in_eof, in_fcs_bad;
   logic [7:0] in_data;
   logic cfg_rx_en, cfg_uc_all, cfg_mc_all, cfg_bc_ok, cfg_long_ok, cfg_keep_bad, cfg_strip_fcs;
   logic [47:0] station_addr;
   logic out_valid, out_sof, out_eof;
   logic [7:0] out_data;
   logic vd_valid, vd_accept, vd_ucast, vd_mcast, vd_bcast, vd_short, vd_long, vd_bad;
   logic [LW-1:0] vd_len;

   eth_rx_filter #(.MIN_LEN(MINL), .MAX_LEN(MAXL), .LEN_W(LW)) i_eth_rx_filter (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
      .in_data(in_data), .in_fcs_bad(in_fcs_bad), .cfg_rx_en(cfg_rx_en),
      .cfg_uc_all(cfg_uc_all), .cfg_mc_all(cfg_mc_all), .cfg_bc_ok(cfg_bc_ok),
      .cfg_long_ok(cfg_long_ok), .cfg_keep_bad(cfg_keep_bad), .cfg_strip_fcs(cfg_strip_fcs),
      .station_addr(station_addr), .out_valid(out_valid), .out_sof(out_sof),
      .out_eof(out_eof), .out_data(out_data), .vd_valid(vd_valid), .vd_accept(vd_accept),
      .vd_ucast(vd_ucast), .vd_mcast(vd_mcast), .vd_bcast(vd_bcast), .vd_short(vd_short),
      .vd_long(vd_long), .vd_bad(vd_bad), .vd_len(vd_len)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // output monitor
   logic [7:0] obuf [256];
   logic [7:0] sbuf [256];
   int o_cnt, sof_n, sof_at, eof_n, eof_at, vd_n, vd_cyc, first_cyc, sof_cyc, eof_cyc;
   logic m_acc, m_uc, m_mc, m_bc, m_sh, m_lg, m_bad;
   int m_len;

   task automatic clear_mon();
      o_cnt = 0; sof_n = 0; sof_at = -1; eof_n = 0; eof_at = -1;
      vd_n = 0; vd_cyc = -1; first_cyc = -1;
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            if (o_cnt < 256) obuf[o_cnt] = out_data;
            if (out_sof) begin sof_n++; sof_at = o_cnt; first_cyc = cyc; end
            if (out_eof) begin eof_n++; eof_at = o_cnt; end
            o_cnt++;
         end
         if (vd_valid) begin
            vd_n++; vd_cyc = cyc;
            m_acc = vd_accept; m_uc = vd_ucast; m_mc = vd_mcast; m_bc = vd_bcast;
            m_sh = vd_short; m_lg = vd_long; m_bad = vd_bad; m_len = int'(vd_len);
         end
      end
   end

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   function automatic logic [7:0] frame_byte(input logic [1:0] code, input int i, input int seed);
      logic [47:0] d;
      case (code)
         2'd0:    d = OWN;
         2'd1:    d = OTHER;
         2'd2:    d = MCAST;
         default: d = '1;
      endcase
      if (i < 6) return d[47-8*i -: 8];
      return 8'((i * 13 + seed * 5 + 3) & 255);
   endfunction

   function automatic string tag_of(input logic [18:0] e);
      if (!e[7])         return "R6";
      if (e[8])          return "R9";
      if (e[16:9] > MAXL) return "R8";
      if (e[16:9] < MINL) return "R7";
      if (e[18:17] == 2'd1) return "R3";
      if (e[18:17] == 2'd2) return "R4";
      if (e[18:17] == 2'd3) return "R5";
      if (e[1])          return "R10";
      return "R2";
   endfunction

   task automatic send(input logic [1:0] code, input int len, input logic bad, input int seed);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         sbuf[i]    = frame_byte(code, i, seed);
         in_valid   = 1'b1;
         in_sof     = (i == 0);
         in_eof     = (i == len - 1);
         in_data    = sbuf[i];
         in_fcs_bad = bad && (i == len - 1);
         if (i == 0) sof_cyc = cyc;
         if (i == len - 1) eof_cyc = cyc;
      end
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_fcs_bad = 1'b0;
      repeat (LAT + 4) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = '0;
      in_fcs_bad = 1'b0; cfg_rx_en = 1'b0; cfg_uc_all = 1'b0; cfg_mc_all = 1'b0;
      cfg_bc_ok = 1'b0; cfg_long_ok = 1'b0; cfg_keep_bad = 1'b0; cfg_strip_fcs = 1'b0;
      station_addr = OWN;
      clear_mon();
      repeat (3) @(negedge clk);
      check("R1", "out_valid in reset", int'(out_valid), 0);
      check("R1", "vd_valid in reset", int'(vd_valid), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", "out_valid after reset", int'(out_valid), 0);
      check("R1", "vd_valid after reset", int'(vd_valid), 0);

      for (int v = 0; v < NV; v++) begin
         logic [18:0] e;
         logic [1:0]  code;
         int len, nexp, mism;
         logic pass;
         string tg;
         e = VEC[v];
         code = e[18:17];
         len  = int'(e[16:9]);
         tg   = tag_of(e);
         cfg_rx_en = e[7]; cfg_uc_all = e[6]; cfg_mc_all = e[5]; cfg_bc_ok = e[4];
         cfg_long_ok = e[3]; cfg_keep_bad = e[2]; cfg_strip_fcs = e[1];
         clear_mon();
         send(code, len, e[8], v);
         pass = e[7] && (code == 2'd0 || (code == 2'd1 && e[6]) ||
                         (code == 2'd2 && e[5]) || (code == 2'd3 && e[4]));
         nexp = pass ? (e[1] ? len - FCS : len) : 0;
         check("R11", "verdicts per frame", vd_n, 1);
         check(tg, "accept", int'(m_acc), int'(e[0]));
         check("R4", "class uc/mc/bc", int'({m_uc, m_mc, m_bc}),
               int'({code < 2'd2, code == 2'd2, code == 2'd3}));
         check("R7", "short flag", int'(m_sh), int'(len < MINL));
         check("R8", "long flag", int'(m_lg), int'(len > MAXL));
         check("R9", "bad flag", int'(m_bad), int'(e[8]));
         check("R10", "reported length", m_len, e[1] ? len - FCS : len);
         check(tg, "bytes delivered", o_cnt, nexp);
         mism = 0;
         for (int i = 0; i < nexp && i < o_cnt; i++) if (obuf[i] !== sbuf[i]) mism++;
         check("R2", "data mismatches", mism, 0);
         if (nexp > 0) begin
            check("R2", "start marker position", sof_at, 0);
            check("R2", "start markers", sof_n, 1);
            check(e[1] ? "R10" : "R2", "end marker position", eof_at, nexp - 1);
         end
      end

      // latency of stream and verdict
      cfg_rx_en = 1'b1; cfg_uc_all = 1'b0; cfg_mc_all = 1'b0; cfg_bc_ok = 1'b0;
      cfg_long_ok = 1'b0; cfg_keep_bad = 1'b0; cfg_strip_fcs = 1'b0;
      clear_mon();
      send(2'd0, 24, 1'b0, 99);
      check("R12", "first byte latency", first_cyc - sof_cyc, LAT + 1);
      check("R11", "verdict latency", vd_cyc - eof_cyc, 1);
      check("R2", "own frame accepted", int'(m_acc), 1);

      // enable cleared: even a promiscuous setup delivers nothing
      cfg_rx_en = 1'b0; cfg_uc_all = 1'b1; cfg_mc_all = 1'b1; cfg_bc_ok = 1'b1;
      cfg_long_ok = 1'b1; cfg_keep_bad = 1'b1;
      clear_mon();
      send(2'd3, 30, 1'b0, 7);
      check("R6", "bytes while disabled", o_cnt, 0);
      check("R6", "accept while disabled", int'(m_acc), 0);

      summary();
      $finish;
   end

endmodule